// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a minimal 32-bit processor core that completes one instruction per clock. Each cycle it presents its program counter on an instruction port, takes back a 32-bit instruction word, and splits it into fields. It reads up to two source operands from a 32-entry register file. One adder then forms either an arithmetic result or a memory address, and the core writes that result to the register file or to a word-organised data port. The supported set is register add and subtract, add with a signed constant, word load and word store.

Both memory ports are combinational reads driven by the surrounding system. A store is committed by the memory on the clock edge that ends the instruction. Two status outputs report the current instruction. One flags an address that is not word aligned. The other flags an encoding the core does not recognise. In both cases the instruction changes no architectural state.

Top module: `lsc_core`

## Requirements
- R1: The register file has 32 registers of 32 bits; reset clears all of them, and a value written to register n (n not 0) is what later reads of n return.
- R2: Register 0 reads as zero at all times; any write aimed at it is dropped.
- R3: Register-format instructions take opcode bits 31:26 = 0, first source in bits 25:21, second source in bits 20:16, destination in bits 15:11, and the operation in bits 5:0. Code 32 writes first + second and code 34 writes first - second, both wrapping modulo 2^32.
- R4: Opcode 8 (add-immediate) writes to the register in bits 20:16 the sum of the register in bits 25:21 and bits 15:0 sign-extended to 32 bits. For example, 0x8000 adds -32768 and 0x7FFF adds 32767.
- R5: Opcode 35 (load) forms the byte address as register[25:21] plus the sign-extended bits 15:0. It drives address bits 31:2 on the data word index and writes the returned word to the register in bits 20:16.
- R6: Opcode 43 (store) uses the same address rule as R5. It drives the value of register[20:16] as write data with the write strobe high, and it changes no register.
- R7: The program counter is 0 during reset and adds 4 on each clock afterwards; it is the instruction port address.
- R8: A load or store whose byte address has bits 1:0 not zero raises the misalignment output. It then drives neither memory strobe, and a misaligned load leaves its destination unchanged.
- R9: Any opcode other than 0, 8, 35 or 43 is flagged on the illegal output, and so is opcode 0 with an operation code other than 32 or 34. Such an instruction writes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_idx | output | 30 | Word index (byte address bits 31:2) |
| dmem_rdata | input | 32 | Word read at dmem_idx |
| dmem_wdata | output | 32 | Store data |
| dmem_re | output | 1 | Load access this cycle |
| dmem_we | output | 1 | Store access, committed at the next rising edge |
| misalign | output | 1 | Current load or store address not word aligned |
| illegal | output | 1 | Current instruction not recognised |

## Verification
The bench targets the sign-extension boundary of the 16-bit constant (0x7FFF against 0x8000). A core that zero-extends stores 0x00007FFF where 0xFFFF7FFF is due. It also drives a negative load offset, which such a core would turn into an index far from the intended word. Writes aimed at register 0 are followed by a store of register 0, so a design that keeps the written value exposes it on the write data. Misaligned loads are followed by a store of their destination. Unrecognised encodings that name register 1 as destination are followed by a store of register 1. In each case stale or updated values show up on the data port, and a design that let the access through shows a write strobe where none may occur. Wrap-around of all-ones plus one, and of zero minus one, catches a result that is truncated or saturated.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned RIDX_W = 5;

   localparam logic [5:0] OPC_REG   = 6'd0;
   localparam logic [5:0] OPC_ADDI  = 6'd8;
   localparam logic [5:0] OPC_LOAD  = 6'd35;
   localparam logic [5:0] OPC_STORE = 6'd43;

   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;

   typedef enum logic [2:0] {
      K_NOP,
      K_ADD,
      K_SUB,
      K_ADDI,
      K_LOAD,
      K_STORE
   } kind_e;

   typedef struct packed {
      kind_e               kind;
      logic [RIDX_W-1:0]   src_a;
      logic [RIDX_W-1:0]   src_b;
      logic [RIDX_W-1:0]   dst;
      logic [WORD_W-1:0]   imm;
      logic                use_imm;
      logic                subtract;
      logic                wr_reg;
      logic                mem_rd;
      logic                mem_wr;
      logic                bad;
   } dec_t;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
   import lsc_pkg::*;
(
   input  logic [WORD_W-1:0] insn,
   output dec_t              dec
);

   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = insn[31:26];
   assign fn  = insn[5:0];

   always_comb begin
      dec          = '0;
      dec.kind     = K_NOP;
      dec.src_a    = insn[25:21];
      dec.src_b    = insn[20:16];
      dec.imm      = {{(WORD_W-16){insn[15]}}, insn[15:0]};
      case (opc)
         OPC_REG: begin
            case (fn)
               FN_ADD: begin
                  dec.kind   = K_ADD;
                  dec.dst    = insn[15:11];
                  dec.wr_reg = 1'b1;
               end
               FN_SUB: begin
                  dec.kind     = K_SUB;
                  dec.dst      = insn[15:11];
                  dec.wr_reg   = 1'b1;
                  dec.subtract = 1'b1;
               end
               default: dec.bad = 1'b1;
            endcase
         end
         OPC_ADDI: begin
            dec.kind    = K_ADDI;
            dec.dst     = insn[20:16];
            dec.use_imm = 1'b1;
            dec.wr_reg  = 1'b1;
         end
         OPC_LOAD: begin
            dec.kind    = K_LOAD;
            dec.dst     = insn[20:16];
            dec.use_imm = 1'b1;
            dec.wr_reg  = 1'b1;
            dec.mem_rd  = 1'b1;
         end
         OPC_STORE: begin
            dec.kind    = K_STORE;
            dec.use_imm = 1'b1;
            dec.mem_wr  = 1'b1;
         end
         default: dec.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 32,
   parameter bit          ZERO_R0 = 1'b1,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [AW-1:0]     rb_addr,
   output logic [DATA_W-1:0] rb_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("lsc_regfile: DEPTH must be a power of two of at least 2");
   end

   logic [DEPTH-1:0][DATA_W-1:0] cells;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (ZERO_R0 && i == 0) begin : g_zero
         assign cells[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == AW'(i))
               q <= wr_data;
         end
         assign cells[i] = q;
      end
   end

   assign ra_data = cells[ra_addr];
   assign rb_data = cells[rb_addr];

   // R1: a write to a nonzero register is visible on a port reading it next cycle
   a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && ra_addr == wr_addr) |=>
         ($stable(ra_addr) |-> ra_data == $past(wr_data)));

   // R2: register 0 never yields a nonzero value
   a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_addr == '0) |-> (rb_data == '0));

endmodule

// File: rtl/lsc_alu.sv
module lsc_alu #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              subtract,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] b_eff;

   assign b_eff = subtract ? ~b : b;
   assign y     = a + b_eff + {{(DATA_W-1){1'b0}}, subtract};

endmodule

// File: rtl/lsc_core.sv
module lsc_core
   import lsc_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned NREG  = 32,
   localparam int unsigned IDX_W = XLEN - 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [IDX_W-1:0] dmem_idx,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_re,
   output logic            dmem_we,
   output logic            misalign,
   output logic            illegal
);

   if (XLEN != WORD_W) begin : g_bad_xlen
      $error("lsc_core: XLEN must equal the fixed instruction width");
   end
   if (NREG != (1 << RIDX_W)) begin : g_bad_nreg
      $error("lsc_core: NREG must match the 5-bit register fields");
   end

   logic [XLEN-1:0] pc;
   dec_t            dec;
   logic [XLEN-1:0] rs_val;
   logic [XLEN-1:0] rt_val;
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] alu_y;
   logic [XLEN-1:0] wb_data;
   logic            is_mem;
   logic            rf_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else
         pc <= pc + XLEN'(4);
   end

   assign imem_addr = pc;

   lsc_decode u_dec (
      .insn (imem_rdata),
      .dec  (dec)
   );

   lsc_regfile #(
      .DATA_W  (XLEN),
      .DEPTH   (NREG),
      .ZERO_R0 (1'b1)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (dec.src_a),
      .ra_data (rs_val),
      .rb_addr (dec.src_b),
      .rb_data (rt_val),
      .wr_en   (rf_we),
      .wr_addr (dec.dst),
      .wr_data (wb_data)
   );

   assign opb = dec.use_imm ? dec.imm : rt_val;

   lsc_alu #(.DATA_W(XLEN)) u_alu (
      .subtract (dec.subtract),
      .a        (rs_val),
      .b        (opb),
      .y        (alu_y)
   );

   assign is_mem     = dec.mem_rd | dec.mem_wr;
   assign misalign   = is_mem && (alu_y[1:0] != 2'b00);
   assign illegal    = dec.bad;
   assign dmem_idx   = alu_y[XLEN-1:2];
   assign dmem_wdata = rt_val;
   assign dmem_re    = dec.mem_rd && !misalign;
   assign dmem_we    = dec.mem_wr && !misalign;
   assign wb_data    = dec.mem_rd ? dmem_rdata : alu_y;
   assign rf_we      = dec.wr_reg && !(dec.mem_rd && misalign);

   // R7: program counter steps by one word per cycle
   a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

   // R8: a misaligned access touches neither memory nor registers
   a_r8_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!dmem_we && !dmem_re && !rf_we));

   // R9: an unrecognised encoding has no side effects
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!dmem_we && !rf_we && !misalign && !dmem_re));

   // R6: a store never writes back
   a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> !rf_we);

   // R3: the subtract result added back to the subtrahend gives the minuend
   a_r3_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      dec.subtract |-> ((alu_y + opb) == rs_val));

endmodule

// File: tb/lsc_core_test.sv
module lsc_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata;
   logic [29:0] dmem_idx;
   logic [31:0] dmem_rdata;
   logic [31:0] dmem_wdata;
   logic        dmem_re;
   logic        dmem_we;
   logic        misalign;
   logic        illegal;

   always #4 clk = ~clk;

   lsc_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_idx   (dmem_idx),
      .dmem_rdata (dmem_rdata),
      .dmem_wdata (dmem_wdata),
      .dmem_re    (dmem_re),
      .dmem_we    (dmem_we),
      .misalign   (misalign),
      .illegal    (illegal)
   );

   logic [31:0] imem [64];
   logic [31:0] dmem [64];

   assign imem_rdata = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_idx[5:0]];

   always @(posedge clk) if (dmem_we) dmem[dmem_idx[5:0]] <= dmem_wdata;

   typedef struct {
      logic [31:0] pc;
      logic        we;
      logic [29:0] idx;
      logic [31:0] wd;
      logic        ill;
      logic        mis;
      string       req;
   } exp_t;

   exp_t q[$];
   int   n_ins = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
   endfunction

   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   task automatic put(logic [31:0] insn, logic we, int byte_addr, logic [31:0] wd,
                      logic ill, logic mis, string req);
      exp_t e;
      imem[n_ins] = insn;
      e.pc  = 32'(n_ins * 4);
      e.we  = we;
      e.idx = 30'(byte_addr / 4);
      e.wd  = wd;
      e.ill = ill;
      e.mis = mis;
      e.req = req;
      q.push_back(e);
      n_ins++;
   endtask

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         imem[i] = enc_r(0, 0, 0, 32);
         dmem[i] = 32'h0;
      end
      dmem[10] = 32'h1234_5678;

      put(enc_i(8, 0, 1, 5),       0, 0, 0, 0, 0, "R4");
      put(enc_i(8, 0, 2, -3),      0, 0, 0, 0, 0, "R4");
      put(enc_r(1, 2, 3, 32),      0, 0, 0, 0, 0, "R3");
      put(enc_r(2, 1, 4, 34),      0, 0, 0, 0, 0, "R3");
      put(enc_i(43, 0, 3, 0),      1, 0,  32'd2, 0, 0, "R3");
      put(enc_i(43, 0, 4, 4),      1, 4,  32'hFFFF_FFF8, 0, 0, "R3");
      put(enc_i(8, 0, 0, 7),       0, 0, 0, 0, 0, "R2");
      put(enc_i(43, 0, 0, 8),      1, 8,  32'd0, 0, 0, "R2");
      put(enc_i(8, 0, 5, 16),      0, 0, 0, 0, 0, "R4");
      put(enc_i(35, 5, 6, -12),    0, 0, 0, 0, 0, "R5");
      put(enc_i(43, 0, 6, 12),     1, 12, 32'hFFFF_FFF8, 0, 0, "R5");
      put(enc_i(43, 5, 6, 1),      0, 0, 0, 0, 1, "R8");
      put(enc_i(35, 0, 7, 2),      0, 0, 0, 0, 1, "R8");
      put(enc_i(43, 0, 7, 16),     1, 16, 32'd0, 0, 0, "R1");
      put(32'hFC00_0000,           0, 0, 0, 1, 0, "R9");
      put(enc_r(2, 2, 1, 7),       0, 0, 0, 1, 0, "R9");
      put(enc_i(43, 0, 1, 20),     1, 20, 32'd5, 0, 0, "R9");
      put(enc_i(8, 0, 8, -1),      0, 0, 0, 0, 0, "R4");
      put(enc_i(8, 0, 11, 1),      0, 0, 0, 0, 0, "R4");
      put(enc_r(8, 11, 10, 32),    0, 0, 0, 0, 0, "R3");
      put(enc_i(43, 0, 10, 24),    1, 24, 32'd0, 0, 0, "R3");
      put(enc_r(0, 11, 12, 34),    0, 0, 0, 0, 0, "R3");
      put(enc_i(43, 0, 12, 28),    1, 28, 32'hFFFF_FFFF, 0, 0, "R3");
      put(enc_i(35, 0, 13, 40),    0, 0, 0, 0, 0, "R5");
      put(enc_i(43, 0, 13, 32),    1, 32, 32'h1234_5678, 0, 0, "R5");
      put(enc_i(8, 8, 14, 16'h8000), 0, 0, 0, 0, 0, "R4");
      put(enc_i(43, 0, 14, 36),    1, 36, 32'hFFFF_7FFF, 0, 0, "R4");
      put(enc_i(8, 0, 15, 16'h7FFF), 0, 0, 0, 0, 0, "R4");
      put(enc_i(43, 0, 15, 44),    1, 44, 32'h0000_7FFF, 0, 0, "R4");
      put(enc_i(43, 5, 11, -4),    1, 12, 32'd1, 0, 0, "R6");
      put(enc_i(35, 0, 16, 12),    0, 0, 0, 0, 0, "R6");
      put(enc_i(43, 0, 16, 48),    1, 48, 32'd1, 0, 0, "R6");
      put(enc_i(43, 0, 11, 52),    1, 52, 32'd1, 0, 0, "R6");
      put(enc_r(0, 0, 0, 32),      0, 0, 0, 0, 0, "R7");
      put(enc_r(0, 0, 0, 32),      0, 0, 0, 0, 0, "R7");

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(imem_addr == 32'd0, "R7", "reset pc", imem_addr, 32'd0);
      chk(dmem_we == 1'b0, "R7", "reset store strobe", 32'(dmem_we), 32'd0);
      @(posedge clk);
      #2 rst_n = 1'b1;

      while (q.size() > 0) begin
         exp_t e;
         @(negedge clk);
         e = q.pop_front();
         chk(imem_addr == e.pc, e.req, "pc", imem_addr, e.pc);
         chk(dmem_we == e.we, e.req, "store strobe", 32'(dmem_we), 32'(e.we));
         chk(illegal == e.ill, e.req, "illegal flag", 32'(illegal), 32'(e.ill));
         chk(misalign == e.mis, e.req, "misalign flag", 32'(misalign), 32'(e.mis));
         if (e.we) begin
            chk(dmem_idx == e.idx, e.req, "word index", 32'(dmem_idx), 32'(e.idx));
            chk(dmem_wdata == e.wd, e.req, "store data", dmem_wdata, e.wd);
         end
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=0", q.size());
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule